// File: doc/BRIEF.md
# Instruction Fetch-Decode Sequencer

This block is the control sequencer and front-end datapath of a small multicycle processor with 16-bit words. It owns the program counter, the memory address and memory data registers, the instruction register, an eight-entry register file and the adder that the ADD instruction needs. It drives a single read port into program memory. Every instruction goes through the same four steps: the PC is copied to the address register, memory is read into the data register, that word moves into the instruction register, and one decode cycle follows. Decode reads the opcode and selects what happens next.

ADD runs a one-cycle execute phase. In that cycle the sum goes onto the internal bus and into the destination register, and the sequencer then starts the next fetch. Any other opcode goes straight back to fetch, and the only effect it leaves is the PC increment that fetch already made. The next PC value is picked by a three-way source mux: the incremented PC, the shared internal bus, or an effective-address input. Outside logic can ask, in the decode cycle, for the PC to be reloaded from the bus or from the effective address. This models a change of control flow.

Top module: `fdx_sequencer`

## Requirements
- R1: A synchronous active-high reset sets PC to 0x3000 and clears IR, MAR, MDR and all eight registers. The `phase` output then reads 0. The phase codes are 0 (fetch-address), 1 (fetch-read), 2 (fetch-load), 3 (decode) and 4 (ADD execute).
- R2: In phase 0 the PC is driven onto the internal bus, so `bus_out` equals PC. At the end of that cycle MAR takes the PC value and PC becomes PC+1, modulo 2^16.
- R3: `mem_rd_en` is high only in phase 1, and `mem_addr` always shows MAR. Memory returns the addressed word within that cycle, and MDR captures `mem_rdata` at the edge that ends phase 1.
- R4: At the edge that ends phase 2, IR takes the MDR value.
- R5: Phases 0, 1, 2 and 3 always follow one another in that order, and decode lasts exactly one cycle. From decode the next phase is 4 when IR[15:12] is 0001 (ADD), and 0 otherwise.
- R6: ADD with IR[5]=0 writes register IR[11:9] with register IR[8:6] plus register IR[2:0], modulo 2^16.
- R7: ADD with IR[5]=1 writes register IR[11:9] with register IR[8:6] plus IR[4:0] sign-extended to 16 bits, modulo 2^16.
- R8: `rf_we` is high only in phase 4. In that cycle the sum is on `bus_out` and equals `rf_wdata`, and the next phase is 0.
- R9: An opcode other than 0001 writes no register and changes none of IR, MAR, MDR or the register file. Only the PC increment made in fetch remains.
- R10: If `redir_req` is high in the decode cycle, PC is loaded from `ea_in` when `redir_sel_ea` is 1, and from `bus_in` when it is 0. In any other phase these inputs have no effect on PC.
- R11: With no redirect, PC during execute holds the address of the word after the current instruction.
- R12: When the ADD destination equals a source register, the source value used is the one from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Read address into program memory (MAR) |
| mem_rd_en | output | 1 | Read enable, high in the fetch-read phase |
| mem_rdata | input | 16 | Word returned by memory |
| bus_in | input | 16 | Value on the shared bus when the block drives nothing onto it |
| ea_in | input | 16 | Effective address offered as a PC source |
| redir_req | input | 1 | Asks for a PC reload during decode |
| redir_sel_ea | input | 1 | Redirect source: 1 effective address, 0 bus |
| phase | output | 3 | Current sequencer phase code |
| pc_q | output | 16 | Program counter |
| ir_q | output | 16 | Instruction register |
| mar_q | output | 16 | Memory address register |
| mdr_q | output | 16 | Memory data register |
| bus_out | output | 16 | Internal bus value |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |

## Verification
Two functions can fall on the same clock edge. In the ADD execute cycle, the destination register is written while the same register is read as a source. In the decode cycle of an ADD, a PC redirect can arrive just as dispatch to execute happens. The program image is built from pseudo-random words, so destination-equals-source cases come up often. `redir_req` is toggled in every phase, so redirects land both on ADD decodes and outside decode. The behavioural model sets the expected result on its own: the sum uses the old source value, the redirected PC shows up in the execute cycle and in the next fetch address, and a request outside decode leaves PC unchanged.

// File: rtl/fdx_pkg.sv
`timescale 1ns/1ps
package fdx_pkg;
  localparam int WORD_W = 16;
  localparam int RF_N   = 8;
  localparam int RF_AW  = $clog2(RF_N);
  localparam int OPC_W  = 4;
  localparam int IMM_W  = 5;
  localparam int PH_W   = 3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RF_AW-1:0]  ridx_t;

  typedef enum logic [PH_W-1:0] {
    PH_FADDR = 3'd0,
    PH_FREAD = 3'd1,
    PH_FLOAD = 3'd2,
    PH_DEC   = 3'd3,
    PH_XADD  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    PCS_INC = 2'd0,
    PCS_BUS = 2'd1,
    PCS_EA  = 2'd2
  } pc_src_e;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;

  typedef struct packed {
    logic    gate_pc;
    logic    ld_pc;
    pc_src_e pc_src;
    logic    ld_mar;
    logic    rd_mem;
    logic    ld_mdr;
    logic    ld_ir;
    logic    gate_alu;
    logic    ld_rf;
  } ctl_t;

  function automatic word_t f_inc(word_t v);
    return v + word_t'(1);
  endfunction

  function automatic word_t f_add(word_t a, word_t b);
    return a + b;
  endfunction

  function automatic word_t f_sext(logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [OPC_W-1:0] f_opcode(word_t ir);
    return ir[WORD_W-1 -: OPC_W];
  endfunction

  function automatic ridx_t f_dst(word_t ir);
    return ir[11:9];
  endfunction

  function automatic ridx_t f_src1(word_t ir);
    return ir[8:6];
  endfunction

  function automatic ridx_t f_src2(word_t ir);
    return ir[2:0];
  endfunction

  function automatic logic f_imm_mode(word_t ir);
    return ir[5];
  endfunction

  function automatic phase_e f_dispatch(logic [OPC_W-1:0] opc);
    return (opc == OPC_ADD) ? PH_XADD : PH_FADDR;
  endfunction
endpackage

// File: rtl/fdx_ctrl.sv
`timescale 1ns/1ps
module fdx_ctrl
  import fdx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             redir_req,
  input  logic             redir_sel_ea,
  output phase_e           phase,
  output ctl_t             ctl
);
  phase_e nxt;

  always_comb begin
    case (phase)
      PH_FADDR: nxt = PH_FREAD;
      PH_FREAD: nxt = PH_FLOAD;
      PH_FLOAD: nxt = PH_DEC;
      PH_DEC:   nxt = f_dispatch(opcode);
      PH_XADD:  nxt = PH_FADDR;
      default:  nxt = PH_FADDR;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.pc_src = PCS_INC;
    case (phase)
      PH_FADDR: begin
        ctl.gate_pc = 1'b1;
        ctl.ld_mar  = 1'b1;
        ctl.ld_pc   = 1'b1;
      end
      PH_FREAD: begin
        ctl.rd_mem = 1'b1;
        ctl.ld_mdr = 1'b1;
      end
      PH_FLOAD: ctl.ld_ir = 1'b1;
      PH_DEC: begin
        if (redir_req) begin
          ctl.ld_pc  = 1'b1;
          ctl.pc_src = redir_sel_ea ? PCS_EA : PCS_BUS;
        end
      end
      PH_XADD: begin
        ctl.gate_alu = 1'b1;
        ctl.ld_rf    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FADDR;
    else     phase <= nxt;
  end

  assert_faddr_next_R5: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FADDR |=> phase == PH_FREAD);
  assert_fread_next_R5: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FREAD |=> phase == PH_FLOAD);
  assert_fload_next_R5: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FLOAD |=> phase == PH_DEC);
  assert_xadd_return_R8: assert property (@(posedge clk) disable iff (rst)
    phase == PH_XADD |=> phase == PH_FADDR);
  assert_gates_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.gate_pc, ctl.gate_alu}));
endmodule

// File: rtl/fdx_pc_unit.sv
`timescale 1ns/1ps
module fdx_pc_unit
  import fdx_pkg::*;
#(
  parameter word_t RESET_PC = 16'h3000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    ld,
  input  pc_src_e src,
  input  word_t   bus,
  input  word_t   ea,
  output word_t   pc
);
  word_t pc_mux;

  always_comb begin
    case (src)
      PCS_BUS: pc_mux = bus;
      PCS_EA:  pc_mux = ea;
      default: pc_mux = f_inc(pc);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     pc <= RESET_PC;
    else if (ld) pc <= pc_mux;
  end

  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(pc));
endmodule

// File: rtl/fdx_regfile.sv
`timescale 1ns/1ps
module fdx_regfile
  import fdx_pkg::*;
#(
  parameter int N = RF_N,
  parameter int W = WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] ra1,
  input  logic [$clog2(N)-1:0] ra2,
  output logic [W-1:0]         rd1,
  output logic [W-1:0]         rd2
);
  localparam int AW = $clog2(N);

  logic [N*W-1:0] flat;

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                             q <= '0;
      else if (we && waddr == AW'(g))      q <= wdata;
    end
    assign flat[g*W +: W] = q;
  end

  assign rd1 = flat[ra1*W +: W];
  assign rd2 = flat[ra2*W +: W];

  assert_rf_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(flat));
  assert_rf_written_R6: assert property (@(posedge clk) disable iff (rst)
    we |=> flat[$past(waddr)*W +: W] == $past(wdata));
endmodule

// File: rtl/fdx_sequencer.sv
`timescale 1ns/1ps
module fdx_sequencer
  import fdx_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC = 16'h3000
) (
  input  logic              clk,
  input  logic              rst,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] bus_in,
  input  logic [WORD_W-1:0] ea_in,
  input  logic              redir_req,
  input  logic              redir_sel_ea,
  output logic [PH_W-1:0]   phase,
  output logic [WORD_W-1:0] pc_q,
  output logic [WORD_W-1:0] ir_q,
  output logic [WORD_W-1:0] mar_q,
  output logic [WORD_W-1:0] mdr_q,
  output logic [WORD_W-1:0] bus_out,
  output logic              rf_we,
  output logic [RF_AW-1:0]  rf_waddr,
  output logic [WORD_W-1:0] rf_wdata
);
  phase_e ph;
  ctl_t   ctl;
  word_t  pc, mar, mdr, ir, bus, alu, rd1, rd2, opb;

  // Named events for the assertions.
  logic ev_fetch_addr, ev_mem_capture, ev_ir_load, ev_redirect, ev_rf_write;
  assign ev_fetch_addr  = ctl.ld_mar;
  assign ev_mem_capture = ctl.ld_mdr;
  assign ev_ir_load     = ctl.ld_ir;
  assign ev_redirect    = ctl.ld_pc && (ctl.pc_src != PCS_INC);
  assign ev_rf_write    = ctl.ld_rf;

  fdx_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .opcode       (f_opcode(ir)),
    .redir_req    (redir_req),
    .redir_sel_ea (redir_sel_ea),
    .phase        (ph),
    .ctl          (ctl)
  );

  fdx_pc_unit #(.RESET_PC(RESET_PC)) u_pc (
    .clk (clk),
    .rst (rst),
    .ld  (ctl.ld_pc),
    .src (ctl.pc_src),
    .bus (bus),
    .ea  (ea_in),
    .pc  (pc)
  );

  fdx_regfile #(.N(RF_N), .W(WORD_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (ev_rf_write),
    .waddr (f_dst(ir)),
    .wdata (bus),
    .ra1   (f_src1(ir)),
    .ra2   (f_src2(ir)),
    .rd1   (rd1),
    .rd2   (rd2)
  );

  // ADD operand select and sum
  assign opb = f_imm_mode(ir) ? f_sext(ir[IMM_W-1:0]) : rd2;
  assign alu = f_add(rd1, opb);

  // Internal bus: at most one gate drives it, otherwise the outside value.
  always_comb begin
    if (ctl.gate_pc)       bus = pc;
    else if (ctl.gate_alu) bus = alu;
    else                   bus = bus_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      if (ev_fetch_addr)  mar <= bus;
      if (ev_mem_capture) mdr <= mem_rdata;
      if (ev_ir_load)     ir  <= mdr;
    end
  end

  assign mem_addr  = mar;
  assign mem_rd_en = ctl.rd_mem;
  assign phase     = ph;
  assign pc_q      = pc;
  assign ir_q      = ir;
  assign mar_q     = mar;
  assign mdr_q     = mdr;
  assign bus_out   = bus;
  assign rf_we     = ev_rf_write;
  assign rf_waddr  = f_dst(ir);
  assign rf_wdata  = bus;

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    ph == PH_FADDR |=> (mar == $past(pc)) && (pc == $past(pc) + 16'd1));
  assert_bus_pc_R2: assert property (@(posedge clk) disable iff (rst)
    ph == PH_FADDR |-> bus_out == pc_q);
  assert_rd_phase_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> ph == PH_FREAD);
  assert_mdr_capture_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> mdr == $past(mem_rdata));
  assert_ir_load_R4: assert property (@(posedge clk) disable iff (rst)
    ph == PH_FLOAD |=> ir == $past(mdr));
  assert_dispatch_add_R5: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DEC && ir[15:12] == 4'b0001) |=> ph == PH_XADD);
  assert_dispatch_other_R9: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DEC && ir[15:12] != 4'b0001) |=> ph == PH_FADDR && $stable(ir) && $stable(mar));
  assert_we_phase_R8: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ph == PH_XADD);
  assert_redir_ea_R10: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DEC && redir_req && redir_sel_ea) |=> pc == $past(ea_in));
  assert_redir_bus_R10: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DEC && redir_req && !redir_sel_ea) |=> pc == $past(bus_in));
  assert_pc_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_FADDR && ph != PH_DEC) |=> $stable(pc));
endmodule

// File: tb/fdx_sequencer_tb.sv
`timescale 1ns/1ps
module fdx_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] mem_addr, mem_rdata, bus_in, ea_in;
  logic        mem_rd_en, redir_req, redir_sel_ea;
  logic [2:0]  phase;
  logic [15:0] pc_q, ir_q, mar_q, mdr_q, bus_out, rf_wdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;

  always #2.5 clk = ~clk;

  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];

  fdx_sequencer u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rdata(mem_rdata), .bus_in(bus_in), .ea_in(ea_in),
    .redir_req(redir_req), .redir_sel_ea(redir_sel_ea), .phase(phase),
    .pc_q(pc_q), .ir_q(ir_q), .mar_q(mar_q), .mdr_q(mdr_q), .bus_out(bus_out),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  int          m_ph;
  logic [15:0] m_pc, m_ir, m_mar, m_mdr;
  logic [15:0] m_rf [0:7];
  bit          rst_q, redir_q;

  function automatic logic [15:0] m_sum();
    int a, b;
    a = int'(m_rf[m_ir[8:6]]);
    if (m_ir[5]) b = int'(m_ir[4:0]) - (m_ir[4] ? 32 : 0);
    else         b = int'(m_rf[m_ir[2:0]]);
    return 16'((a + b) & 32'hFFFF);
  endfunction

  always @(posedge clk) begin
    cyc++;
    rst_q = rst;
    if (rst) begin
      m_ph = 0; m_pc = 16'h3000; m_ir = '0; m_mar = '0; m_mdr = '0;
      for (int i = 0; i < 8; i++) m_rf[i] = '0;
      redir_q = 0;
    end else begin
      case (m_ph)
        0: begin m_mar = m_pc; m_pc = m_pc + 16'd1; m_ph = 1; redir_q = 0; end
        1: begin m_mdr = mem[m_mar[7:0]]; m_ph = 2; end
        2: begin m_ir = m_mdr; m_ph = 3; end
        3: begin
          if (redir_req) begin
            m_pc = redir_sel_ea ? ea_in : bus_in;
            redir_q = 1;
          end
          m_ph = (m_ir[15:12] == 4'b0001) ? 4 : 0;
        end
        default: begin m_rf[m_ir[11:9]] = m_sum(); m_ph = 0; end
      endcase
    end
    if (cyc > 50000 && !done) begin
      n_bad++;
      $display("FAIL R5 watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Compare on every falling edge, before inputs move
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      string tg;
      bit coll;
      tg = rst_q ? "R1" : "R5";
      chk(tg, "phase", 16'(phase), 16'(m_ph));
      tg = rst_q ? "R1" : (m_ph == 4 ? "R11" : (redir_q ? "R10" : "R2"));
      chk(tg, "pc", pc_q, m_pc);
      chk(rst_q ? "R1" : "R2", "mar", mar_q, m_mar);
      chk(rst_q ? "R1" : "R3", "mdr", mdr_q, m_mdr);
      chk(rst_q ? "R1" : (m_ph == 0 ? "R9" : "R4"), "ir", ir_q, m_ir);
      chk("R3", "mem_addr", mem_addr, m_mar);
      chk("R3", "mem_rd_en", 16'(mem_rd_en), 16'(m_ph == 1));
      chk((m_ph == 3 && m_ir[15:12] != 4'b0001) ? "R9" : "R8", "rf_we",
          16'(rf_we), 16'(m_ph == 4));
      if (m_ph == 0)      chk("R2", "bus_out", bus_out, m_pc);
      else if (m_ph == 4) chk("R8", "bus_out", bus_out, m_sum());
      else                chk("R10", "bus_out", bus_out, bus_in);
      if (m_ph == 4) begin
        coll = (m_ir[11:9] == m_ir[8:6]) || (!m_ir[5] && m_ir[11:9] == m_ir[2:0]);
        tg = coll ? "R12" : (m_ir[5] ? "R7" : "R6");
        chk(tg, "rf_waddr", 16'(rf_waddr), 16'(m_ir[11:9]));
        chk(tg, "rf_wdata", rf_wdata, m_sum());
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      int unsigned r;
      r = rnd();
      if ((r % 8) < 5) mem[i] = {4'b0001, 12'(r >> 4)};
      else             mem[i] = 16'(r >> 3);
    end
    rst = 1'b1; redir_req = 1'b0; redir_sel_ea = 1'b0;
    bus_in = 16'h0; ea_in = 16'h0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      #1;
      begin
        int unsigned r;
        r = rnd();
        redir_req    = ((r % 5) == 0);
        redir_sel_ea = r[9];
        bus_in       = (r % 97 == 0) ? 16'hFFFF : 16'(rnd());
        ea_in        = 16'(rnd());
        rst          = (k >= 2000 && k < 2002);
      end
    end
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule